// File: doc/BRIEF.md
# Three-Wire Motion Sensor Serial Master

This block is the host side of a half-duplex link to an optical motion sensor. The link has three wires: a serial clock, a single data line that both ends take turns driving, and an active-low chip select. A command is offered on a valid/ready port. The block then frames the transfer with chip select, shifts the bytes, and hands the data line between itself and the sensor. When the command is complete, it reports the results. The pad tristate buffer lives outside the block, so the data line appears here as separate output-enable, output and input signals.

Five command codes are supported. A register read and a register write each pass a raw address byte, and its top bit is sent unchanged. A motion burst reads the X delta and the Y delta and then drops chip select, which ends the burst early. A resynchronisation pulse briefly lowers chip select. A signature check reads three identification registers and compares the values. Every delay is a whole number of microseconds, counted from the system clock by a prescaler derived from the `CLK_HZ` parameter.

Top module: `tw_sensor_master`

## Requirements
- R1: After reset and whenever `busy` is low, `cs_n` and `sclk` are high, `sd_oe` is low and `cmd_ready` is high.
- R2: Every byte has 8 bits and is shifted most-significant bit first in both directions. A byte read from the sensor appears unchanged on the result output.
- R3: Each written bit drives `sd_oe`=1 and sets `sd_out` on the falling edge of `sclk`. It then holds `sclk` low for exactly 2 us, keeps `sd_out` stable, and raises `sclk`. `sd_oe` is high only while `cs_n` is low.
- R4: Each read bit drives `sd_oe`=0 and holds `sclk` low for exactly 1 us. `sd_in` is sampled as `sclk` rises, and `sclk` then stays high for 1 us.
- R5: After the eighth rising clock of any written byte, at least 4 us pass before the next `sclk` fall or the next `cs_n` rise.
- R6: Read (`cmd_op`=0, codes 5 to 7 behave the same): inside one chip-select frame the block writes `cmd_addr` and reads one byte. It keeps `cs_n` low for at least 1 us more, then loads the byte into `rd_data`.
- R7: Write (`cmd_op`=1): inside one chip-select frame the block writes `cmd_addr` and then `cmd_wdata`.
- R8: Burst (`cmd_op`=2): the block writes `BURST_ADDR` and reads exactly two bytes before raising `cs_n`. The first byte goes to `dx` and the second to `dy`, each as a signed two's-complement value.
- R9: Sync (`cmd_op`=3): `cs_n` goes low for exactly 1 us with no `sclk` edge, then returns high.
- R10: Signature (`cmd_op`=4): the block does three framed reads of `ID0_ADDR`, `ID1_ADDR` and `ID2_ADDR`, in that order. `sig_ok` is 1 only if the three bytes are 0x12, 0x01 and 0x26 respectively.
- R11: `busy` rises on the cycle after a command is accepted (`cmd_valid` and `cmd_ready` both high). `done` pulses for exactly one cycle as `busy` falls, and the result outputs are valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_op | input | 3 | 0 read, 1 write, 2 burst, 3 sync, 4 signature |
| cmd_addr | input | 8 | Address byte for read and write |
| cmd_wdata | input | 8 | Data byte for write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte from the last register read |
| dx | output | 8 | Signed X delta from the last burst |
| dy | output | 8 | Signed Y delta from the last burst |
| sig_ok | output | 1 | Result of the last signature check |
| sclk | output | 1 | Serial clock to the sensor |
| cs_n | output | 1 | Active-low chip select |
| sd_oe | output | 1 | Data pad output enable |
| sd_out | output | 1 | Data pad output value |
| sd_in | input | 1 | Data pad input value |

## Verification
A wrong bit counter or a wrong shift direction shows as a wrong byte. That byte appears at the sensor model when the address frame closes, or on `rd_data`, `dx` or `dy` at the next `done`. A prescaler or microsecond-count error changes the length of a clock-low phase, which is measured on the next `sclk` rise, or it shortens the gap after a written byte, which shows at the very next edge. A sequencer that loses its place shows within one cycle: the idle lines are checked on every clock, so a chip select held low while idle, or a data line driven outside a frame, is caught at once. A wrong number of burst bytes is caught at the moment chip select rises.

// File: rtl/tw_sensor_pkg.sv
package tw_sensor_pkg;

  localparam int NUS_W = 3;

  // Phase lengths in microseconds
  localparam logic [NUS_W-1:0] T_WBIT_US  = 3'd2;
  localparam logic [NUS_W-1:0] T_GAP_US   = 3'd4;
  localparam logic [NUS_W-1:0] T_RHALF_US = 3'd1;
  localparam logic [NUS_W-1:0] T_HOLD_US  = 3'd1;
  localparam logic [NUS_W-1:0] T_SYNC_US  = 3'd1;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_BURST = 3'd2,
    OP_SYNC  = 3'd3,
    OP_SIGN  = 3'd4
  } op_e;

  function automatic logic [7:0] sig_expect(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h12;
      2'd1:    return 8'h01;
      default: return 8'h26;
    endcase
  endfunction

endpackage

// File: rtl/tw_us_timer.sv
module tw_us_timer
  import tw_sensor_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUS_W-1:0] n_us,
  output logic             fire
);
  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);

  logic [PRE_W-1:0] pre;
  logic [NUS_W-1:0] left;
  logic             run;

  assign fire = run && (pre == PRE_LAST) && (left == NUS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      pre  <= '0;
      left <= '0;
    end else if (go) begin
      run  <= 1'b1;
      pre  <= '0;
      left <= n_us;
    end else if (run) begin
      if (pre == PRE_LAST) begin
        pre <= '0;
        if (left == NUS_W'(1)) run <= 1'b0;
        else left <= left - NUS_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/tw_byte_engine.sv
module tw_byte_engine
  import tw_sensor_pkg::*;
#(
  parameter int CYC_PER_US = 50
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       go_rd,
  input  logic [7:0] go_byte,
  input  logic       sd_in,
  output logic       done,
  output logic [7:0] rbyte,
  output logic       sclk,
  output logic       sd_out,
  output logic       sd_oe
);
  typedef enum logic [2:0] {E_IDLE, E_WLOW, E_WHI, E_WGAP, E_RLOW, E_RHI} est_e;

  est_e             st;
  logic [7:0]       sh;
  logic [2:0]       cnt;
  logic             t_go;
  logic [NUS_W-1:0] t_n;
  logic             t_fire;
  logic             take;

  tw_us_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk(clk), .rst(rst), .go(t_go), .n_us(t_n), .fire(t_fire)
  );

  assign done  = t_fire && ((st == E_WGAP) || ((st == E_RHI) && (cnt == 3'd7)));
  assign take  = go && ((st == E_IDLE) || done);
  assign rbyte = sh;

  always_comb begin
    t_go = 1'b0;
    t_n  = T_RHALF_US;
    if (take) begin
      t_go = 1'b1;
      t_n  = go_rd ? T_RHALF_US : T_WBIT_US;
    end else begin
      case (st)
        E_WHI: begin
          t_go = 1'b1;
          t_n  = (cnt == 3'd7) ? T_GAP_US : T_WBIT_US;
        end
        E_RLOW: t_go = t_fire;
        E_RHI:  t_go = t_fire && (cnt != 3'd7);
        default: t_go = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= E_IDLE;
      sh     <= '0;
      cnt    <= '0;
      sclk   <= 1'b1;
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else if (take) begin
      cnt  <= '0;
      sclk <= 1'b0;
      if (go_rd) begin
        sd_oe <= 1'b0;
        st    <= E_RLOW;
      end else begin
        sd_oe  <= 1'b1;
        sd_out <= go_byte[7];
        sh     <= go_byte;
        st     <= E_WLOW;
      end
    end else begin
      case (st)
        E_WLOW: if (t_fire) begin
          sclk <= 1'b1;
          st   <= E_WHI;
        end
        E_WHI: begin
          if (cnt == 3'd7) begin
            st <= E_WGAP;
          end else begin
            cnt    <= cnt + 3'd1;
            sh     <= {sh[6:0], 1'b0};
            sd_out <= sh[6];
            sclk   <= 1'b0;
            st     <= E_WLOW;
          end
        end
        E_WGAP: if (t_fire) begin
          sd_oe <= 1'b0;
          st    <= E_IDLE;
        end
        E_RLOW: if (t_fire) begin
          sh   <= {sh[6:0], sd_in};
          sclk <= 1'b1;
          st   <= E_RHI;
        end
        E_RHI: if (t_fire) begin
          if (cnt == 3'd7) begin
            st <= E_IDLE;
          end else begin
            cnt  <= cnt + 3'd1;
            sclk <= 1'b0;
            st   <= E_RLOW;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_cmd_seq.sv
module tw_cmd_seq
  import tw_sensor_pkg::*;
#(
  parameter int         CYC_PER_US = 50,
  parameter logic [7:0] BURST_ADDR = 8'h50,
  parameter logic [7:0] ID0_ADDR   = 8'h00,
  parameter logic [7:0] ID1_ADDR   = 8'h01,
  parameter logic [7:0] ID2_ADDR   = 8'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic signed [7:0] dx,
  output logic signed [7:0] dy,
  output logic              sig_ok,
  output logic              cs_n,
  output logic              eng_go,
  output logic              eng_rd,
  output logic [7:0]        eng_byte,
  input  logic              eng_done,
  input  logic [7:0]        eng_rbyte
);
  typedef enum logic [3:0] {
    S_IDLE, S_SEL, S_ADDR, S_WDAT, S_RD0, S_RD1, S_HOLD, S_DESEL, S_RESEL, S_SYNC, S_FIN
  } sst_e;

  sst_e             st;
  op_e              op_q;
  logic [7:0]       addr_q, wdat_q, b0, b1;
  logic [1:0]       idx;
  logic             match;
  logic             t_go, t_fire;
  logic [NUS_W-1:0] t_n;
  logic [7:0]       frame_addr;

  tw_us_timer #(.CYC_PER_US(CYC_PER_US)) u_tmr (
    .clk(clk), .rst(rst), .go(t_go), .n_us(t_n), .fire(t_fire)
  );

  assign cmd_ready = (st == S_IDLE);

  always_comb begin
    case (op_q)
      OP_BURST: frame_addr = BURST_ADDR;
      OP_SIGN:  frame_addr = (idx == 2'd0) ? ID0_ADDR : (idx == 2'd1) ? ID1_ADDR : ID2_ADDR;
      default:  frame_addr = addr_q;
    endcase
  end

  always_comb begin
    eng_go   = 1'b0;
    eng_rd   = 1'b0;
    eng_byte = frame_addr;
    t_go     = 1'b0;
    t_n      = T_HOLD_US;
    case (st)
      S_IDLE: if (cmd_valid && (op_e'(cmd_op) == OP_SYNC)) begin
        t_go = 1'b1;
        t_n  = T_SYNC_US;
      end
      S_SEL: eng_go = 1'b1;
      S_ADDR: if (eng_done) begin
        eng_go   = 1'b1;
        eng_rd   = (op_q != OP_WRITE);
        eng_byte = wdat_q;
      end
      S_RD0: if (eng_done) begin
        if (op_q == OP_BURST) begin
          eng_go = 1'b1;
          eng_rd = 1'b1;
        end else begin
          t_go = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdat_q  <= '0;
      b0      <= '0;
      b1      <= '0;
      idx     <= '0;
      match   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      dx      <= '0;
      dy      <= '0;
      sig_ok  <= 1'b0;
      cs_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          op_q   <= op_e'(cmd_op);
          addr_q <= cmd_addr;
          wdat_q <= cmd_wdata;
          idx    <= '0;
          match  <= 1'b1;
          busy   <= 1'b1;
          cs_n   <= 1'b0;
          st     <= (op_e'(cmd_op) == OP_SYNC) ? S_SYNC : S_SEL;
        end
        S_SEL:  st <= S_ADDR;
        S_ADDR: if (eng_done) st <= (op_q == OP_WRITE) ? S_WDAT : S_RD0;
        S_WDAT: if (eng_done) st <= S_DESEL;
        S_RD0: if (eng_done) begin
          b0 <= eng_rbyte;
          if (op_q == OP_SIGN) match <= match && (eng_rbyte == sig_expect(idx));
          st <= (op_q == OP_BURST) ? S_RD1 : S_HOLD;
        end
        S_RD1: if (eng_done) begin
          b1 <= eng_rbyte;
          st <= S_DESEL;
        end
        S_HOLD: if (t_fire) st <= S_DESEL;
        S_DESEL: begin
          cs_n <= 1'b1;
          if ((op_q == OP_SIGN) && (idx != 2'd2)) begin
            idx <= idx + 2'd1;
            st  <= S_RESEL;
          end else begin
            st <= S_FIN;
          end
        end
        S_RESEL: begin
          cs_n <= 1'b0;
          st   <= S_SEL;
        end
        S_SYNC: if (t_fire) begin
          cs_n <= 1'b1;
          st   <= S_FIN;
        end
        S_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          case (op_q)
            OP_BURST: begin
              dx <= $signed(b0);
              dy <= $signed(b1);
            end
            OP_SIGN:  sig_ok <= match;
            OP_WRITE, OP_SYNC: ;
            default:  rd_data <= b0;
          endcase
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_sensor_master.sv
module tw_sensor_master #(
  parameter int         CLK_HZ     = 50_000_000,
  parameter logic [7:0] BURST_ADDR = 8'h50,
  parameter logic [7:0] ID0_ADDR   = 8'h00,
  parameter logic [7:0] ID1_ADDR   = 8'h01,
  parameter logic [7:0] ID2_ADDR   = 8'h3E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [7:0]        cmd_addr,
  input  logic [7:0]        cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data,
  output logic signed [7:0] dx,
  output logic signed [7:0] dy,
  output logic              sig_ok,
  output logic              sclk,
  output logic              cs_n,
  output logic              sd_oe,
  output logic              sd_out,
  input  logic              sd_in
);
  localparam int CYC_RAW    = CLK_HZ / 1_000_000;
  localparam int CYC_PER_US = (CYC_RAW < 1) ? 1 : CYC_RAW;

  logic       eng_go, eng_rd, eng_done;
  logic [7:0] eng_byte, eng_rbyte;

  tw_cmd_seq #(
    .CYC_PER_US(CYC_PER_US), .BURST_ADDR(BURST_ADDR),
    .ID0_ADDR(ID0_ADDR), .ID1_ADDR(ID1_ADDR), .ID2_ADDR(ID2_ADDR)
  ) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .dx(dx), .dy(dy),
    .sig_ok(sig_ok), .cs_n(cs_n), .eng_go(eng_go), .eng_rd(eng_rd),
    .eng_byte(eng_byte), .eng_done(eng_done), .eng_rbyte(eng_rbyte)
  );

  tw_byte_engine #(.CYC_PER_US(CYC_PER_US)) u_eng (
    .clk(clk), .rst(rst), .go(eng_go), .go_rd(eng_rd), .go_byte(eng_byte),
    .sd_in(sd_in), .done(eng_done), .rbyte(eng_rbyte), .sclk(sclk),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );
endmodule

// File: rtl/tw_sensor_master_chk.sv
module tw_sensor_master_chk (
  input logic clk,
  input logic rst,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic sd_oe,
  input logic sd_out
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && sclk && !sd_oe));

  // R3
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> !cs_n);

  // R3
  wbit_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sd_oe && !sclk) |=> (sclk || !sd_oe || $stable(sd_out)));

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> busy);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind tw_sensor_master tw_sensor_master_chk u_chk (.*);

// File: tb/test_tw_sensor_master.sv
module test_tw_sensor_master;
  localparam int         US    = 8;
  localparam logic [7:0] BURST = 8'h50;
  localparam logic [7:0] ID0   = 8'h00;
  localparam logic [7:0] ID1   = 8'h01;
  localparam logic [7:0] ID2   = 8'h3E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op    = '0;
  logic [7:0]        cmd_addr  = '0;
  logic [7:0]        cmd_wdata = '0;
  logic              cmd_ready, busy, done, sig_ok, sclk, cs_n, sd_oe, sd_out;
  logic [7:0]        rd_data;
  logic signed [7:0] dx, dy;
  logic              sdi = 1'b0;

  tw_sensor_master #(.CLK_HZ(US * 1_000_000), .BURST_ADDR(BURST),
    .ID0_ADDR(ID0), .ID1_ADDR(ID1), .ID2_ADDR(ID2)) i_tw_sensor_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .dx(dx), .dy(dy),
    .sig_ok(sig_ok), .sclk(sclk), .cs_n(cs_n), .sd_oe(sd_oe),
    .sd_out(sd_out), .sd_in(sdi)
  );

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=%0d expected<%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Behavioural sensor: register file plus burst delta bytes
  logic [7:0] mem [128];
  logic [7:0] bx = 8'h00, by = 8'h00;
  logic [7:0] addr_log [$];

  logic       pv_sclk = 1'b1, pv_cs = 1'b1;
  int         bitc = 0, rbit = 0, rbytes = 0, edges = 0, phase = 0;
  int         t_fall = 0, t_csfall = 0, t_bend = 0;
  bit         pend = 1'b0;
  logic [7:0] rx = '0, fa = 8'hFF, cur = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (pv_cs && !cs_n) begin
        t_csfall = cyc; bitc = 0; rbit = 0; rbytes = 0; phase = 0; edges = 0; fa = 8'hFF;
      end
      if (!cs_n) begin
        if (!pv_sclk && sclk) begin
          edges++;
          if (sd_oe) begin
            chk(cyc - t_fall == 2 * US, "R3", "write bit low cycles", cyc - t_fall, 2 * US);
            rx = {rx[6:0], sd_out};
            bitc++;
            if (bitc == 8) begin
              bitc = 0; t_bend = cyc; pend = 1'b1;
              if (phase == 0) begin
                fa = rx; addr_log.push_back(rx);
                phase = rx[7] ? 1 : 2;
              end else if (phase == 1) begin
                mem[fa[6:0]] = rx; phase = 3;
              end
            end
          end else begin
            chk(cyc - t_fall == US, "R4", "read bit low cycles", cyc - t_fall, US);
          end
        end
        if (pv_sclk && !sclk) begin
          edges++;
          t_fall = cyc;
          if (pend) begin
            chk(cyc - t_bend >= 4 * US, "R5", "gap before next fall", cyc - t_bend, 4 * US);
            pend = 1'b0;
          end
          if (!sd_oe && phase == 2) begin
            if (rbit == 0) begin
              cur = (fa == BURST) ? ((rbytes == 0) ? bx : by) : mem[fa[6:0]];
              rbytes++;
            end
            sdi  = cur[7 - rbit];
            rbit = (rbit + 1) % 8;
          end
        end
      end
      if (!pv_cs && cs_n) begin
        if (pend) begin
          chk(cyc - t_bend >= 4 * US, "R5", "gap before cs rise", cyc - t_bend, 4 * US);
          pend = 1'b0;
        end
        if (edges == 0)
          chk(cyc - t_csfall == US, "R9", "sync low cycles", cyc - t_csfall, US);
        if (fa == BURST && edges != 0)
          chk(rbytes == 2, "R8", "burst bytes read", rbytes, 2);
      end
      chk(busy || (cs_n && sclk && !sd_oe), "R1", "idle lines", {cs_n, sclk, sd_oe}, 3'b110);
      chk(!sd_oe || !cs_n, "R3", "drive outside frame", sd_oe, 0);
      pv_sclk = sclk;
      pv_cs   = cs_n;
    end
  end

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
    chk(cmd_ready, "R11", "ready before accept", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R11", "busy after accept", busy, 1);
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done && !busy, "R11", "done with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R11", "done lasts one cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3);
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n && sclk && !sd_oe, "R1", "reset lines", {cs_n, sclk, sd_oe}, 3'b110);
    chk(!busy && !done && cmd_ready, "R1", "reset handshake", {busy, done, cmd_ready}, 3'b001);

    // R7 write then R6 read back
    addr_log.delete();
    do_cmd(3'd1, 8'h85, 8'hA7);
    chk(mem[5] == 8'hA7, "R7", "sensor got write data", mem[5], 8'hA7);
    chk(addr_log.size() == 1 && addr_log[0] == 8'h85, "R7", "one address byte", addr_log[0], 8'h85);
    do_cmd(3'd0, 8'h05, 8'h00);
    chk(rd_data == 8'hA7, "R6", "read back", rd_data, 8'hA7);

    // R2 bit order
    mem[8'h10] = 8'h01; mem[8'h11] = 8'h80; mem[8'h12] = 8'h00;
    do_cmd(3'd0, 8'h10, 8'h00);
    chk(rd_data == 8'h01, "R2", "lsb-only byte", rd_data, 8'h01);
    do_cmd(3'd0, 8'h11, 8'h00);
    chk(rd_data == 8'h80, "R2", "msb-only byte", rd_data, 8'h80);
    do_cmd(3'd0, 8'h12, 8'h00);
    chk(rd_data == 8'h00, "R2", "zero byte", rd_data, 8'h00);
    do_cmd(3'd1, 8'h93, 8'h01);
    chk(mem[8'h13] == 8'h01, "R2", "written lsb-only byte", mem[8'h13], 8'h01);

    // R8 bursts
    bx = 8'h80; by = 8'h7F; addr_log.delete();
    do_cmd(3'd2, 8'h00, 8'h00);
    chk(dx == -128, "R8", "dx min", int'(dx), -128);
    chk(dy == 127, "R8", "dy max", int'(dy), 127);
    chk(addr_log.size() == 1 && addr_log[0] == BURST, "R8", "burst address", addr_log[0], BURST);
    chk(rd_data == 8'h00, "R6", "rd_data held over burst", rd_data, 8'h00);
    bx = 8'hFF; by = 8'h01;
    do_cmd(3'd2, 8'h00, 8'h00);
    chk(dx == -1, "R8", "dx minus one", int'(dx), -1);
    chk(dy == 1, "R8", "dy plus one", int'(dy), 1);
    bx = 8'h00; by = 8'h80;
    do_cmd(3'd2, 8'h00, 8'h00);
    chk(dx == 0, "R8", "dx zero", int'(dx), 0);
    chk(dy == -128, "R8", "dy min", int'(dy), -128);

    // R9 sync pulse
    addr_log.delete();
    do_cmd(3'd3, 8'h00, 8'h00);
    chk(addr_log.size() == 0, "R9", "no bytes in sync", addr_log.size(), 0);

    // R10 signature
    mem[ID0[6:0]] = 8'h12; mem[ID1[6:0]] = 8'h01; mem[ID2[6:0]] = 8'h26;
    addr_log.delete();
    do_cmd(3'd4, 8'h00, 8'h00);
    chk(sig_ok == 1'b1, "R10", "matching ids", sig_ok, 1);
    chk(addr_log.size() == 3, "R10", "three frames", addr_log.size(), 3);
    if (addr_log.size() == 3) begin
      chk(addr_log[0] == ID0, "R10", "first id address", addr_log[0], ID0);
      chk(addr_log[1] == ID1, "R10", "second id address", addr_log[1], ID1);
      chk(addr_log[2] == ID2, "R10", "third id address", addr_log[2], ID2);
    end
    mem[ID2[6:0]] = 8'h27;
    do_cmd(3'd4, 8'h00, 8'h00);
    chk(sig_ok == 1'b0, "R10", "last id wrong", sig_ok, 0);
    mem[ID0[6:0]] = 8'h26; mem[ID2[6:0]] = 8'h12;
    do_cmd(3'd4, 8'h00, 8'h00);
    chk(sig_ok == 1'b0, "R10", "ids reversed", sig_ok, 0);
    mem[ID0[6:0]] = 8'h12; mem[ID2[6:0]] = 8'h26;
    do_cmd(3'd4, 8'h00, 8'h00);
    chk(sig_ok == 1'b1, "R10", "ids restored", sig_ok, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule